// File: doc/BRIEF.md
# Interrupt Pending and Acceptance Controller

This block keeps the eight-level interrupt-pending field of a processor's control coprocessor and decides whether the core should take an interrupt. Two command channels change the field. The post channel sets one level. The clear channel removes one level. A separate clear-all strobe empties the whole field. Any of these can arrive in the same cycle, and a fixed precedence settles which one wins. A level number outside the legal range does not change the field. Instead it raises a one-cycle error pulse.

The block also watches the free-running cycle counter and its compare value. When they are equal and the counter is not zero, a timer event occurs. The event sets the pending bit chosen by a three-bit timer-select input. It also counts toward the pending status in that same cycle. A timer bit stays set until software clears it.

Acceptance depends on three status conditions: global enable must be set, and both the error-level and exception-level flags must be clear. When they hold, the block requests an interrupt if the mask is non-zero and the pending status is non-zero. This is a test on each field as a whole. It does not AND the mask and pending fields bit by bit. The request is registered, so it appears one cycle after its condition.

Top module: `irq_pend_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `pending` is 8'h00 and `take_req` and `cmd_err` are 0.
- R2: A post with `post_lvl` = n, where n is in 0..7 (4-bit level field), sets `pending[n]` at the next clock edge. All other bits keep their values.
- R3: A clear with `clr_lvl` = n, where n is in 0..7, clears `pending[n]` only. When `clr_all` is asserted, `pending` becomes 8'h00 at the next edge.
- R4: Precedence within one cycle: `clr_all` beats every set. A clear of bit n beats a post or timer set of the same bit n.
- R5: A post or clear whose level is 8..15 leaves `pending` unchanged. It drives `cmd_err` high for exactly the cycle after the command.
- R6: A timer event occurs when `compare` == `count` and `count` != 0. On a timer event, `pending[timer_sel]` is set at the next edge.
- R7: When `count` is 0, equal `count` and `compare` values never set a pending bit.
- R8: A bit set by a timer event stays set after `count` moves past `compare`, until a clear or clear-all removes it.
- R9: `any_pend` is combinational and is 1 exactly when `pending` is non-zero or a timer event is present in the current cycle.
- R10: `take_req` is 0 in the cycle after `gie` = 0, `erl` = 1 or `exl` = 1, whatever the pending and mask values are.
- R11: With the gates open, `take_req` equals the registered value of (`im` != 0 AND `any_pend`). This is a whole-field test, so `im` = 8'h01 with `pending` = 8'h80 still requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| post_vld | input | 1 | Post command strobe |
| post_lvl | input | 4 | Level to post |
| clr_vld | input | 1 | Clear command strobe |
| clr_lvl | input | 4 | Level to clear |
| clr_all | input | 1 | Clear every pending level |
| gie | input | 1 | Global interrupt enable |
| erl | input | 1 | Error-level flag (blocks acceptance) |
| exl | input | 1 | Exception-level flag (blocks acceptance) |
| im | input | 8 | Interrupt mask field |
| count | input | 32 | Cycle counter value |
| compare | input | 32 | Timer compare value |
| timer_sel | input | 3 | Pending bit the timer event sets |
| pending | output | 8 | Pending field |
| any_pend | output | 1 | Pending field or current timer event non-zero |
| take_req | output | 1 | Registered interrupt-take request |
| cmd_err | output | 1 | One-cycle pulse after an out-of-range level |

## Verification
The hardest case to reach from the ports is a timer event that lands in the same cycle as a clear of its own selected bit, or as a clear-all. The stimulus first sets `count` equal to `compare`, then asserts the clear in that same low clock phase, so that both reach one edge. A second hard case is the zero-count match. Here `count` and `compare` are both driven to zero while no command is active, and the bench confirms that `pending` and `any_pend` stay low. The whole-field acceptance rule is checked with a mask bit and a pending bit that do not overlap.

// File: rtl/irq_pend_pkg.sv
// Package: default sizes shared by the pending controller and its bench.
// Assumes the level field is wide enough to encode out-of-range levels.
package irq_pend_pkg;
    localparam int IRQ_LEVELS = 8;
    localparam int IRQ_LVL_W  = 4;
    localparam int IRQ_CNT_W  = 32;
endpackage

// File: rtl/irq_lvl_decode.sv
// Module: irq_lvl_decode
// Turns one command (strobe plus level number) into a one-hot bit mask.
// A level at or beyond NUM_LEVELS gives an empty mask and flags illegal.
// Assumes LVL_W can hold the value NUM_LEVELS.
module irq_lvl_decode #(
    parameter int NUM_LEVELS = 8,
    parameter int LVL_W      = 4
) (
    input  logic                  vld,
    input  logic [LVL_W-1:0]      lvl,
    output logic [NUM_LEVELS-1:0] mask,
    output logic                  illegal
);
    // Range check of the requested level.
    always_comb begin
        illegal = vld && (lvl >= LVL_W'(NUM_LEVELS));
    end

    // One mask bit per legal level.
    for (genvar i = 0; i < NUM_LEVELS; i++) begin : g_bit
        always_comb begin
            mask[i] = vld && (lvl == LVL_W'(i));
        end
    end
endmodule

// File: rtl/irq_timer_match.sv
// Module: irq_timer_match
// Detects the on-core timer event (compare equals a non-zero count) and
// steers it onto the pending bit named by the timer-select field.
// Assumes the select field is wide enough to name every level.
module irq_timer_match #(
    parameter int NUM_LEVELS = 8,
    parameter int CNT_W      = 32,
    localparam int SEL_W     = $clog2(NUM_LEVELS)
) (
    input  logic [CNT_W-1:0]      count,
    input  logic [CNT_W-1:0]      compare,
    input  logic [SEL_W-1:0]      sel,
    output logic                  event_o,
    output logic [NUM_LEVELS-1:0] set_mask
);
    // Equality with the zero-count exclusion.
    always_comb begin
        event_o = (count == compare) && (count != '0);
    end

    // Route the event to the selected level.
    for (genvar i = 0; i < NUM_LEVELS; i++) begin : g_sel
        always_comb begin
            set_mask[i] = event_o && (sel == SEL_W'(i));
        end
    end
endmodule

// File: rtl/irq_pend_field.sv
// Module: irq_pend_field
// Holds the pending field. Precedence: clear-all, then per-bit clear,
// then sets (post or timer). Synchronous active-low reset to zero.
module irq_pend_field #(
    parameter int NUM_LEVELS = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_LEVELS-1:0] set_mask,
    input  logic [NUM_LEVELS-1:0] clr_mask,
    input  logic                  clr_all,
    output logic [NUM_LEVELS-1:0] field_q
);
    logic [NUM_LEVELS-1:0] field_d;

    // Next-state: apply sets, then clears, with clear-all overriding.
    always_comb begin
        if (clr_all) begin
            field_d = '0;
        end else begin
            field_d = (field_q | set_mask) & ~clr_mask;
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            field_q <= '0;
        end else begin
            field_q <= field_d;
        end
    end
endmodule

// File: rtl/irq_take_gate.sv
// Module: irq_take_gate
// Registers the take request from the three status gates, the whole
// mask field and the pending status. Also registers the error pulse.
module irq_take_gate #(
    parameter int NUM_LEVELS = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  gie,
    input  logic                  erl,
    input  logic                  exl,
    input  logic [NUM_LEVELS-1:0] im,
    input  logic                  any_pend,
    input  logic                  bad_cmd,
    output logic                  take_q,
    output logic                  err_q
);
    logic gates_open;

    // Acceptance gate from the status flags.
    always_comb begin
        gates_open = gie && !erl && !exl;
    end

    // Request and error registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            take_q <= gates_open && (im != '0) && any_pend;
            err_q  <= bad_cmd;
        end
    end
endmodule

// File: rtl/irq_pend_ctrl.sv
// Module: irq_pend_ctrl (top)
// Pending-field controller: two command decoders, the timer match, the
// pending register and the acceptance gate. any_pend includes a timer
// event in the current cycle; take_req and cmd_err are registered.
module irq_pend_ctrl #(
    parameter int NUM_LEVELS = irq_pend_pkg::IRQ_LEVELS,
    parameter int LVL_W      = irq_pend_pkg::IRQ_LVL_W,
    parameter int CNT_W      = irq_pend_pkg::IRQ_CNT_W,
    localparam int SEL_W     = $clog2(NUM_LEVELS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  post_vld,
    input  logic [LVL_W-1:0]      post_lvl,
    input  logic                  clr_vld,
    input  logic [LVL_W-1:0]      clr_lvl,
    input  logic                  clr_all,
    input  logic                  gie,
    input  logic                  erl,
    input  logic                  exl,
    input  logic [NUM_LEVELS-1:0] im,
    input  logic [CNT_W-1:0]      count,
    input  logic [CNT_W-1:0]      compare,
    input  logic [SEL_W-1:0]      timer_sel,
    output logic [NUM_LEVELS-1:0] pending,
    output logic                  any_pend,
    output logic                  take_req,
    output logic                  cmd_err
);
    logic [NUM_LEVELS-1:0] post_mask, clr_mask, tmr_mask, set_mask;
    logic                  post_bad, clr_bad, tmr_evt;

    irq_lvl_decode #(.NUM_LEVELS(NUM_LEVELS), .LVL_W(LVL_W)) u_post_dec (
        .vld(post_vld), .lvl(post_lvl), .mask(post_mask), .illegal(post_bad)
    );

    irq_lvl_decode #(.NUM_LEVELS(NUM_LEVELS), .LVL_W(LVL_W)) u_clr_dec (
        .vld(clr_vld), .lvl(clr_lvl), .mask(clr_mask), .illegal(clr_bad)
    );

    irq_timer_match #(.NUM_LEVELS(NUM_LEVELS), .CNT_W(CNT_W)) u_tmr (
        .count(count), .compare(compare), .sel(timer_sel),
        .event_o(tmr_evt), .set_mask(tmr_mask)
    );

    // Merge the two set sources.
    always_comb begin
        set_mask = post_mask | tmr_mask;
    end

    irq_pend_field #(.NUM_LEVELS(NUM_LEVELS)) u_field (
        .clk(clk), .rst_n(rst_n), .set_mask(set_mask), .clr_mask(clr_mask),
        .clr_all(clr_all), .field_q(pending)
    );

    // Pending status seen this cycle, timer event included.
    always_comb begin
        any_pend = (pending != '0) || tmr_evt;
    end

    irq_take_gate #(.NUM_LEVELS(NUM_LEVELS)) u_gate (
        .clk(clk), .rst_n(rst_n), .gie(gie), .erl(erl), .exl(exl), .im(im),
        .any_pend(any_pend), .bad_cmd(post_bad || clr_bad),
        .take_q(take_req), .err_q(cmd_err)
    );
endmodule

// File: rtl/irq_pend_chk.sv
// Module: irq_pend_chk
// Property checker bound to irq_pend_ctrl; observes ports only.
module irq_pend_chk #(
    parameter int NUM_LEVELS = 8,
    parameter int LVL_W      = 4,
    parameter int CNT_W      = 32,
    localparam int SEL_W     = $clog2(NUM_LEVELS)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  post_vld,
    input logic [LVL_W-1:0]      post_lvl,
    input logic                  clr_vld,
    input logic [LVL_W-1:0]      clr_lvl,
    input logic                  clr_all,
    input logic                  gie,
    input logic                  erl,
    input logic                  exl,
    input logic [NUM_LEVELS-1:0] im,
    input logic [CNT_W-1:0]      count,
    input logic [CNT_W-1:0]      compare,
    input logic [SEL_W-1:0]      timer_sel,
    input logic [NUM_LEVELS-1:0] pending,
    input logic                  any_pend,
    input logic                  take_req,
    input logic                  cmd_err
);
    p_post_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (post_vld && post_lvl < LVL_W'(NUM_LEVELS) && !clr_all &&
         !(clr_vld && clr_lvl == post_lvl))
        |=> pending[int'($past(post_lvl))]);

    p_clear_all_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all |=> (pending == '0));

    p_clr_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_vld && clr_lvl < LVL_W'(NUM_LEVELS)) |=> !pending[int'($past(clr_lvl))]);

    p_bad_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((post_vld && post_lvl >= LVL_W'(NUM_LEVELS)) ||
         (clr_vld && clr_lvl >= LVL_W'(NUM_LEVELS))) |=> cmd_err);

    p_timer_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (count == compare && count != '0 && !clr_all &&
         !(clr_vld && clr_lvl == LVL_W'(timer_sel)))
        |=> pending[int'($past(timer_sel))]);

    p_zero_cnt_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0 && !post_vld && !clr_vld && !clr_all)
        |=> (pending == $past(pending)));

    p_gates_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!gie || erl || exl) |=> !take_req);

    p_take_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (gie && !erl && !exl && im != '0 && any_pend) |=> take_req);

    // R9: a non-zero field is always reported as pending.
    always @(negedge clk) begin
        if (rst_n) begin
            p_any_r9: assert ((pending == '0) || any_pend);
        end
    end
endmodule

bind irq_pend_ctrl irq_pend_chk #(
    .NUM_LEVELS(NUM_LEVELS), .LVL_W(LVL_W), .CNT_W(CNT_W)
) u_chk (.*);

// File: tb/test_irq_pend_ctrl.sv
// Directed bench for irq_pend_ctrl: one task per scenario, each checking
// its own results at the falling edge after the relevant rising edge.
module test_irq_pend_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        post_vld, clr_vld, clr_all, gie, erl, exl;
    logic [3:0]  post_lvl, clr_lvl;
    logic [7:0]  im;
    logic [31:0] count, compare;
    logic [2:0]  timer_sel;
    logic [7:0]  pending;
    logic        any_pend, take_req, cmd_err;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    irq_pend_ctrl i_irq_pend_ctrl (
        .clk(clk), .rst_n(rst_n), .post_vld(post_vld), .post_lvl(post_lvl),
        .clr_vld(clr_vld), .clr_lvl(clr_lvl), .clr_all(clr_all),
        .gie(gie), .erl(erl), .exl(exl), .im(im), .count(count),
        .compare(compare), .timer_sel(timer_sel), .pending(pending),
        .any_pend(any_pend), .take_req(take_req), .cmd_err(cmd_err)
    );

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Advance one rising edge and return to the falling edge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        post_vld = 0; clr_vld = 0; clr_all = 0;
        post_lvl = 0; clr_lvl = 0;
        count = 32'd5; compare = 32'd9;
    endtask

    task automatic t_reset();
        rst_n = 0; idle();
        gie = 1; erl = 0; exl = 0; im = 8'hFF; timer_sel = 3'd7;
        step(); step();
        rst_n = 1;
        check("R1 pending", 32'(pending), 0);
        check("R1 take", 32'(take_req), 0);
        check("R1 err", 32'(cmd_err), 0);
    endtask

    task automatic t_post_clear();
        post_vld = 1; post_lvl = 4'd3; step();
        post_lvl = 4'd0; step(); post_vld = 0;
        check("R2 post", 32'(pending), 32'h09);
        clr_vld = 1; clr_lvl = 4'd3; step(); clr_vld = 0;
        check("R3 clear one", 32'(pending), 32'h01);
        post_vld = 1; post_lvl = 4'd6; step(); post_vld = 0;
        clr_all = 1; step(); clr_all = 0;
        check("R3 clear all", 32'(pending), 0);
    endtask

    task automatic t_priority();
        post_vld = 1; post_lvl = 4'd5; clr_vld = 1; clr_lvl = 4'd5; step();
        check("R4 clear beats post", 32'(pending), 0);
        post_lvl = 4'd2; clr_lvl = 4'd5; step();
        check("R4 other bit posts", 32'(pending), 32'h04);
        clr_vld = 0; post_lvl = 4'd7; clr_all = 1; step();
        post_vld = 0; clr_all = 0;
        check("R4 clear-all beats post", 32'(pending), 0);
    endtask

    task automatic t_illegal();
        post_vld = 1; post_lvl = 4'd1; step(); post_vld = 0;
        post_vld = 1; post_lvl = 4'd9; step(); post_vld = 0;
        check("R5 post ignored", 32'(pending), 32'h02);
        check("R5 err pulse", 32'(cmd_err), 1);
        clr_vld = 1; clr_lvl = 4'd15; step(); clr_vld = 0;
        check("R5 clear ignored", 32'(pending), 32'h02);
        check("R5 err on clear", 32'(cmd_err), 1);
        step();
        check("R5 err one cycle", 32'(cmd_err), 0);
        clr_all = 1; step(); clr_all = 0;
    endtask

    task automatic t_timer();
        timer_sel = 3'd6; count = 32'd40; compare = 32'd40; #1;
        check("R9 any on timer event", 32'(any_pend), 1);
        step();
        count = 32'd41;
        check("R6 timer bit", 32'(pending), 32'h40);
        step(); step();
        check("R8 sticky", 32'(pending), 32'h40);
        clr_vld = 1; clr_lvl = 4'd6; step(); clr_vld = 0;
        check("R8 cleared", 32'(pending), 0);
        count = 32'd0; compare = 32'd0; #1;
        check("R7 zero no any", 32'(any_pend), 0);
        step();
        check("R7 zero no set", 32'(pending), 0);
        count = 32'd77; compare = 32'd77; clr_vld = 1; clr_lvl = 4'd6; step();
        clr_vld = 0; count = 32'd78;
        check("R4 clear beats timer", 32'(pending), 0);
    endtask

    task automatic t_take();
        im = 8'h01; post_vld = 1; post_lvl = 4'd7; step(); post_vld = 0;
        check("R9 any", 32'(any_pend), 1);
        step();
        check("R11 whole-field take", 32'(take_req), 1);
        im = 8'h00; step();
        check("R11 zero mask", 32'(take_req), 0);
        im = 8'hFF; gie = 0; step();
        check("R10 gie", 32'(take_req), 0);
        gie = 1; erl = 1; step();
        check("R10 erl", 32'(take_req), 0);
        erl = 0; exl = 1; step();
        check("R10 exl", 32'(take_req), 0);
        exl = 0; step();
        check("R11 reopened", 32'(take_req), 1);
        clr_all = 1; step(); clr_all = 0;
        check("R9 any clear", 32'(any_pend), 0);
        step();
        check("R11 drops", 32'(take_req), 0);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_post_clear();
        t_priority();
        t_illegal();
        t_timer();
        t_take();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule